// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is the control-port slave of a mixed-signal device. An external host reaches a small bank of 8-bit configuration registers over three wires: an active-low chip-select, a serial clock and one data line that both directions share. Each transaction is a 16-bit frame. Its first half carries a header, and its second half carries either write data from the host or read data from the slave.

All three serial pins are brought into a faster system clock through two-flop synchronizers. Their edges are detected in that domain. The system clock must run at least four times faster than the serial clock. The data line is split into an input, an output and an output enable, so that the pad's tristate buffer sits outside the block. The output enable is high only while the slave drives read data.

Top module: `sctl_slave`

## Requirements
- R1: A frame is sent most significant bit first, one bit per serial clock rising edge, and holds 16 bits: bits 15..14 carry the device code, bit 13 is the direction flag (1 = write, 0 = read), bits 12..8 carry the register address and bits 7..0 carry the data.
- R2: A write frame with device code 2'b10 and all 16 rising edges updates the addressed register when chip-select returns high. The new value is visible to any later read.
- R3: In a read frame with device code 2'b10, the output enable goes high after the falling serial clock edge that follows the 8th rising edge. Data bits 7..0 are launched on that falling edge and on the next seven, so the host samples them on rising edges 9 to 16.
- R4: The output enable is low during the header, during every write frame and whenever chip-select is high. It drops within four system clocks of chip-select rising.
- R5: A frame whose device code is not 2'b10 changes no register and never raises the output enable.
- R6: A write frame that ends (chip-select rises) after fewer than 16 rising edges is discarded, and the addressed register keeps its value.
- R7: Rising edges after the 16th within one frame are ignored. A write commits the data carried by bits 7..0 of the first 16 bits.
- R8: Reads of addresses 0x00 to 0x0B and 0x0D to 0x0F return the stored value. Reads of 0x0C and of 0x10 to 0x1F return 0x00.
- R9: While the active-low reset input is low, every register returns to 0x00 and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset / power-down |
| scs_n | input | 1 | Serial chip-select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Data line as seen at the pad input |
| sdio_o | output | 1 | Read data to drive onto the data line |
| sdio_oe | output | 1 | Output enable for the data line pad buffer |

## Verification
The hardest situation to reach is the exact turnaround point. The output enable must rise only on the falling edge after the eighth rising edge, and only when the header decoded as a valid read, so the bench has to observe the pin during every half period of the serial clock. It drives each frame bit by bit and samples the enable and data at the end of each low phase, for every header bit and every data bit. It does this over full-address sweeps of reads and writes, over frames with wrong device codes, over frames cut short and over frames with surplus clocks. Reads of the hole at 0x0C and of the upper half of the address space follow writes that carried nonzero data to those addresses, so a returned zero shows masking rather than an empty register.

// File: rtl/sctl_pkg.sv
`timescale 1ns/1ps
package sctl_pkg;

  // Phases of one chip-select window.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,  // chip-select high
    ST_HDR   = 3'd1,  // collecting device code, direction and address
    ST_WRITE = 3'd2,  // header accepted, host sends data
    ST_READ  = 3'd3,  // header accepted, slave returns data
    ST_SKIP  = 3'd4   // device code mismatch, frame ignored
  } sctl_state_e;

  // Number of header bits for a given field layout.
  function automatic int unsigned hdr_bits(input int unsigned dev_w,
                                           input int unsigned addr_w);
    return dev_w + 1 + addr_w;
  endfunction

endpackage

// File: rtl/sctl_sync.sv
`timescale 1ns/1ps
module sctl_sync #(
  parameter int unsigned       N       = 3,
  parameter logic [N-1:0]      RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[g];
        s2 <= RST_VAL[g];
        s3 <= RST_VAL[g];
      end else begin
        s1 <= pin[g];
        s2 <= s1;
        s3 <= s2;
      end
    end

    assign lvl[g]  = s2;
    assign rise[g] = s2 & ~s3;
    assign fall[g] = ~s2 & s3;
  end

endmodule

// File: rtl/sctl_frame.sv
`timescale 1ns/1ps
module sctl_frame
  import sctl_pkg::*;
#(
  parameter int unsigned      DEV_W  = 2,
  parameter int unsigned      ADDR_W = 5,
  parameter int unsigned      DATA_W = 8,
  parameter logic [DEV_W-1:0] DEV_ID = 2'b10,
  localparam int unsigned HDR_BITS   = DEV_W + 1 + ADDR_W,
  localparam int unsigned FRAME_BITS = HDR_BITS + DATA_W,
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_rise,
  input  logic              cs_fall,
  input  logic              clk_rise,
  input  logic              clk_fall,
  input  logic              din,
  output logic              wr_en,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              tx_start,
  output logic              tx_shift,
  output logic              tx_stop,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              dev_ok,
  output logic              is_read
);

  localparam logic [CNT_W-1:0] HDR_CNT  = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);

  sctl_state_e             st;
  logic [FRAME_BITS-1:0]   shreg;
  logic [HDR_BITS-1:0]     hdr_q;
  logic [CNT_W-1:0]        cnt;
  logic [HDR_BITS-1:0]     hdr_next;
  logic [DEV_W-1:0]        dev_next;
  logic                    wr_next;

  assign hdr_next = {shreg[HDR_BITS-2:0], din};
  assign dev_next = hdr_next[HDR_BITS-1 -: DEV_W];
  assign wr_next  = hdr_next[ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      shreg <= '0;
      hdr_q <= '0;
      cnt   <= '0;
    end else if (cs_rise) begin
      st <= ST_IDLE;
    end else if (cs_fall) begin
      st  <= ST_HDR;
      cnt <= '0;
    end else if (clk_rise && st != ST_IDLE && cnt != FULL_CNT) begin
      shreg <= {shreg[FRAME_BITS-2:0], din};
      cnt   <= cnt + 1'b1;
      if (st == ST_HDR && cnt == HDR_CNT - 1'b1) begin
        hdr_q <= hdr_next;
        if (dev_next != DEV_ID) st <= ST_SKIP;
        else if (wr_next)       st <= ST_WRITE;
        else                    st <= ST_READ;
      end
    end
  end

  assign wr_en    = cs_rise && st == ST_WRITE && cnt == FULL_CNT;
  assign wr_data  = shreg[DATA_W-1:0];
  assign addr     = hdr_q[ADDR_W-1:0];
  assign tx_start = clk_fall && st == ST_READ && cnt == HDR_CNT;
  assign tx_shift = clk_fall && st == ST_READ && cnt > HDR_CNT && cnt < FULL_CNT;
  assign tx_stop  = cs_rise | cs_fall;
  assign bit_cnt  = cnt;
  assign dev_ok   = hdr_q[HDR_BITS-1 -: DEV_W] == DEV_ID;
  assign is_read  = ~hdr_q[ADDR_W];

endmodule

// File: rtl/sctl_regs.sv
`timescale 1ns/1ps
module sctl_regs #(
  parameter int unsigned        ADDR_W    = 5,
  parameter int unsigned        DATA_W    = 8,
  parameter int unsigned        NUM_REGS  = 16,
  parameter int unsigned        HOLE_ADDR = 12,
  parameter logic [DATA_W-1:0]  RESET_VAL = '0,
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_q
);

  localparam logic [ADDR_W:0]   LIMIT = (ADDR_W + 1)'(NUM_REGS);
  localparam logic [ADDR_W-1:0] HOLE  = ADDR_W'(HOLE_ADDR);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic              wr_hit;
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic              rd_ok;

  assign wr_hit = wr_en && ({1'b0, wr_addr} < LIMIT);
  assign wr_idx = wr_addr[IDX_W-1:0];
  assign rd_idx = rd_addr[IDX_W-1:0];
  assign rd_ok  = ({1'b0, rd_addr} < LIMIT) && (rd_addr != HOLE);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                q <= RESET_VAL;
      else if (wr_hit && wr_idx == IDX_W'(g))    q <= wr_data;
    end
    assign regs[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_ok) rd_q <= regs[rd_idx];
    else            rd_q <= '0;
  end

endmodule

// File: rtl/sctl_tx.sv
`timescale 1ns/1ps
module sctl_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              shift,
  input  logic              stop,
  input  logic [DATA_W-1:0] data,
  output logic              sdo,
  output logic              oe
);

  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
      oe <= 1'b0;
    end else if (stop) begin
      oe <= 1'b0;
    end else if (start) begin
      sh <= data;
      oe <= 1'b1;
    end else if (shift) begin
      sh <= {sh[DATA_W-2:0], 1'b0};
    end
  end

  assign sdo = sh[DATA_W-1];

endmodule

// File: rtl/sctl_slave.sv
`timescale 1ns/1ps
module sctl_slave #(
  parameter int unsigned DEV_W     = 2,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 8,
  parameter logic [DEV_W-1:0] DEV_ID = 2'b10,
  parameter int unsigned NUM_REGS  = 16,
  parameter int unsigned HOLE_ADDR = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scs_n,
  input  logic sclk,
  input  logic sdio_i,
  output logic sdio_o,
  output logic sdio_oe
);

  localparam int unsigned HDR_BITS   = sctl_pkg::hdr_bits(DEV_W, ADDR_W);
  localparam int unsigned FRAME_BITS = HDR_BITS + DATA_W;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);

  // Pin order in the synchronizer: [2] chip-select, [1] serial clock, [0] data.
  logic [2:0] pin_lvl, pin_rise, pin_fall;

  logic              cs_rise, cs_fall, sclk_rise, sclk_fall;
  logic              wr_en, tx_start, tx_shift, tx_stop, dev_ok, is_read;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wr_data, rd_q;
  logic [CNT_W-1:0]  bit_cnt;

  sctl_sync #(.N(3), .RST_VAL(3'b110)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  ({scs_n, sclk, sdio_i}),
    .lvl  (pin_lvl),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  assign cs_rise   = pin_rise[2];
  assign cs_fall   = pin_fall[2];
  assign sclk_rise = pin_rise[1];
  assign sclk_fall = pin_fall[1];

  sctl_frame #(
    .DEV_W (DEV_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .DEV_ID(DEV_ID)
  ) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_rise (cs_rise),
    .cs_fall (cs_fall),
    .clk_rise(sclk_rise),
    .clk_fall(sclk_fall),
    .din     (pin_lvl[0]),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .tx_start(tx_start),
    .tx_shift(tx_shift),
    .tx_stop (tx_stop),
    .bit_cnt (bit_cnt),
    .dev_ok  (dev_ok),
    .is_read (is_read)
  );

  sctl_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .HOLE_ADDR(HOLE_ADDR)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(addr),
    .wr_data(wr_data),
    .rd_addr(addr),
    .rd_q   (rd_q)
  );

  sctl_tx #(.DATA_W(DATA_W)) u_tx (
    .clk  (clk),
    .rst_n(rst_n),
    .start(tx_start),
    .shift(tx_shift),
    .stop (tx_stop),
    .data (rd_q),
    .sdo  (sdio_o),
    .oe   (sdio_oe)
  );

endmodule

// File: rtl/sctl_chk.sv
`timescale 1ns/1ps
module sctl_chk #(
  parameter int unsigned CNT_W      = 5,
  parameter int unsigned HDR_BITS   = 8,
  parameter int unsigned FRAME_BITS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scs_n,
  input logic             sdio_o,
  input logic             sdio_oe,
  input logic             sclk_fall,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             dev_ok,
  input logic             is_read,
  input logic             wr_en
);

  // R4: chip-select high for four samples forces the enable low
  a_r4_release_on_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (scs_n && $past(scs_n) && $past(scs_n, 2) && $past(scs_n, 3)) |-> !sdio_oe);

  // R5: the pin is driven only for an accepted read header
  a_r5_drive_needs_dev: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> (dev_ok && is_read));

  // R3: the turnaround happens with exactly the header consumed
  a_r3_oe_after_header: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> (bit_cnt == CNT_W'(HDR_BITS)));

  // R3: driven data changes only after a serial clock falling edge
  a_r3_shift_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sdio_oe && $past(sdio_oe) && (sdio_o != $past(sdio_o))) |-> $past(sclk_fall));

  // R2 / R6: a commit needs a full accepted write frame and a chip-select rise
  a_r2_commit_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(scs_n, 2) && bit_cnt == CNT_W'(FRAME_BITS) && dev_ok && !is_read));

endmodule

bind sctl_slave sctl_chk #(
  .CNT_W     (CNT_W),
  .HDR_BITS  (HDR_BITS),
  .FRAME_BITS(FRAME_BITS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scs_n    (scs_n),
  .sdio_o   (sdio_o),
  .sdio_oe  (sdio_oe),
  .sclk_fall(sclk_fall),
  .bit_cnt  (bit_cnt),
  .dev_ok   (dev_ok),
  .is_read  (is_read),
  .wr_en    (wr_en)
);

// File: tb/tb_sctl_slave.sv
`timescale 1ns/1ps
module tb_sctl_slave;

  localparam int HALF = 8;   // system clocks per serial half period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scs_n = 1'b1;
  logic sclk = 1'b1;
  logic sdio_i = 1'b0;
  logic sdio_o, sdio_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] model [32];
  logic [7:0] got;
  int         oe_in, oe_bad;
  logic       oe_end, oe_rel;

  always #2.5 clk = ~clk;

  sctl_slave dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scs_n  (scs_n),
    .sclk   (sclk),
    .sdio_i (sdio_i),
    .sdio_o (sdio_o),
    .sdio_oe(sdio_oe)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] visible(input int a);
    return (a < 16 && a != 12) ? model[a] : 8'h00;
  endfunction

  task automatic frame(input logic [1:0] dev, input logic wr, input logic [4:0] a,
                       input logic [7:0] d, input int nrise);
    logic [15:0] w;
    w = {dev, wr, a, d};
    got = '0;
    oe_in = 0;
    oe_bad = 0;
    @(negedge clk);
    scs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nrise; i++) begin
      sclk = 1'b0;
      sdio_i = (i < 16) ? w[15-i] : i[0];
      wait_clk(HALF);
      if (i >= 8 && i < 16 && !wr && dev == 2'b10) begin
        if (sdio_oe) oe_in++;
        got[15-i] = sdio_o;
      end else if (sdio_oe) begin
        oe_bad++;
      end
      sclk = 1'b1;
      wait_clk(HALF);
    end
    oe_end = sdio_oe;
    scs_n = 1'b1;
    wait_clk(6);
    oe_rel = sdio_oe;
    wait_clk(HALF);
  endtask

  task automatic rd_check(input string req, input logic [4:0] a, input logic [7:0] exp);
    frame(2'b10, 1'b0, a, 8'hA5, 16);
    chk(req, $sformatf("read addr 0x%0h", a), got, exp);
    chk("R3", "enable during data bits", oe_in, 8);
    chk("R4", "enable during header", oe_bad, 0);
    chk("R4", "enable after cs rise", oe_rel, 0);
  endtask

  task automatic wr_frame(input string req, input logic [4:0] a, input logic [7:0] d);
    frame(2'b10, 1'b1, a, d, 16);
    chk("R4", "enable during write frame", oe_bad + int'(oe_end), 0);
    if (a < 16) model[a] = d;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    wait_clk(5);
    chk("R9", "enable in reset", sdio_oe, 0);
    rst_n = 1'b1;
    wait_clk(5);

    // R9: all registers zero after reset
    for (int a = 0; a < 32; a++) rd_check("R9", 5'(a), 8'h00);

    // R1 R2: write sweep with computed pattern
    for (int a = 0; a < 32; a++) wr_frame("R2", 5'(a), 8'((a * 37 + 8'h5A) & 8'hFF));

    // R1 R8: read back, hole and upper half read zero
    for (int a = 0; a < 32; a++) rd_check("R8", 5'(a), visible(a));

    // R1: MSB-first check with walking ones
    for (int b = 0; b < 8; b++) begin
      wr_frame("R1", 5'd9, 8'(1 << b));
      rd_check("R1", 5'd9, 8'(1 << b));
    end

    // R5: wrong device codes neither write nor drive
    for (int dv = 0; dv < 4; dv++) begin
      if (dv == 2) continue;
      frame(2'(dv), 1'b1, 5'd3, 8'hC3, 16);
      chk("R5", "enable on foreign write", oe_bad + int'(oe_end), 0);
      frame(2'(dv), 1'b0, 5'd3, 8'h00, 16);
      chk("R5", "enable on foreign read", oe_bad + int'(oe_end), 0);
      rd_check("R5", 5'd3, visible(3));
    end

    // R6: truncated writes are discarded
    for (int n = 8; n < 16; n++) begin
      frame(2'b10, 1'b1, 5'd4, 8'h3C, n);
      rd_check("R6", 5'd4, visible(4));
    end

    // R7: surplus clocks after bit 16 ignored
    frame(2'b10, 1'b1, 5'd6, 8'h81, 20);
    model[6] = 8'h81;
    rd_check("R7", 5'd6, 8'h81);
    frame(2'b10, 1'b1, 5'd7, 8'h7E, 23);
    model[7] = 8'h7E;
    rd_check("R7", 5'd7, 8'h7E);

    // R9: reset mid-run clears registers
    @(negedge clk);
    rst_n = 1'b0;
    wait_clk(4);
    chk("R9", "enable in second reset", sdio_oe, 0);
    rst_n = 1'b1;
    wait_clk(4);
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    for (int a = 0; a < 16; a++) rd_check("R9", 5'(a), 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule